// File: doc/BRIEF.md
# Keyboard Scan-Code Event Decoder

This block sits behind a serial keyboard receiver and turns its stream of received bytes into key events. Each byte arrives with a one-cycle valid strobe. Two byte values act as prefixes: one marks the following key as an extended key, the other marks the following key as released. A byte that is not a prefix ends the sequence. The block then emits one event carrying that byte as the key code, together with the extended and release flags that the preceding prefixes set.

A key that is held down makes the keyboard resend its code at intervals. Each resent code is reported as a new press event, so the consumer sees auto-repeat without any extra logic. Codes pass through unchanged: shift state, character mapping and traffic toward the keyboard are left to other logic. A synchronous clear input and a receiver error input both drop any prefix that is pending, so a corrupted byte cannot leave a stale flag attached to the next key.

Top module: `kbd_scan_decoder`

## Requirements
- R1: A valid byte that is neither prefix value (extended prefix 0xE0, release prefix 0xF0), received with no prefix pending, raises `keyStrobe` for exactly the next cycle, with `keyCode` equal to that byte and `keyExt`=0 and `keyRelease`=0. Any such byte value, including 0x00 and 0xFF, passes through unchanged.
- R2: The release prefix 0xF0 followed by a code byte produces one event with `keyRelease`=1 and `keyExt`=0.
- R3: The extended prefix 0xE0 followed by a code byte produces one event with `keyExt`=1 and `keyRelease`=0.
- R4: The sequence 0xE0, 0xF0, code produces one event with both `keyExt`=1 and `keyRelease`=1. Both prefixes are kept whatever order they arrive in.
- R5: Repeated code bytes, including bytes on back-to-back cycles, each produce their own press event.
- R6: A prefix byte never raises `keyStrobe`. A pending prefix survives any number of idle cycles until the code byte arrives.
- R7: Both prefix flags clear once an event is emitted, so the next lone code byte gives a plain press.
- R8: `clearIn` or `rxError` high in a cycle drops all pending prefixes. Any byte valid in that same cycle is ignored and raises no event.
- R9: Between events, `keyCode`, `keyExt` and `keyRelease` hold the values of the last event.
- R10: While `rstN` is low, all outputs are 0 and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte |
| clearIn | input | 1 | Drop pending prefixes |
| rxError | input | 1 | Receiver framing or parity error; drops pending prefixes |
| keyCode | output | 8 | Code of the last event |
| keyExt | output | 1 | Last event came from an extended key |
| keyRelease | output | 1 | Last event was a key release |
| keyStrobe | output | 1 | One-cycle pulse per event |

## Verification
The bench builds the block with its default parameters: an 8-bit code and the prefix values 0xE0 and 0xF0. With those values, every prefix combination can be driven: single prefixes, both prefixes in either order, and duplicated prefixes. A behavioural model compares all outputs on every cycle. Its stimulus covers back-to-back code bytes and prefixes separated by idle gaps. It also covers a clear or an error landing between a prefix and its code, and one landing on the same cycle as a byte.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  // Strobes from the prefix control to the output datapath
  typedef struct packed {
    logic emit;     // final code byte accepted this cycle
    logic extFlag;  // extended prefix was pending
    logic relFlag;  // release prefix was pending
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    PFX_NONE   = 2'b00,
    PFX_EXT    = 2'b01,
    PFX_BRK    = 2'b10,
    PFX_EXTBRK = 2'b11
  } pfxState_t;
endpackage

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] EXT_BYTE = 8'hE0,
  parameter logic [CODE_W-1:0] BRK_BYTE = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [CODE_W-1:0] byteData,
  input  logic              clearIn,
  input  logic              rxError,
  output ctlStrobe_t        ctl
);
  pfxState_t pfxState, pfxNext;
  logic extPend, brkPend, isExt, isBrk, dropAll;

  assign extPend = (pfxState == PFX_EXT) || (pfxState == PFX_EXTBRK);
  assign brkPend = (pfxState == PFX_BRK) || (pfxState == PFX_EXTBRK);
  assign isExt   = (byteData == EXT_BYTE);
  assign isBrk   = (byteData == BRK_BYTE);
  assign dropAll = clearIn || rxError;

  always_comb begin
    pfxNext     = pfxState;
    ctl.emit    = 1'b0;
    ctl.extFlag = extPend;
    ctl.relFlag = brkPend;
    if (dropAll) begin
      pfxNext = PFX_NONE;
    end else if (byteValid) begin
      if (isExt) begin
        pfxNext = brkPend ? PFX_EXTBRK : PFX_EXT;
      end else if (isBrk) begin
        pfxNext = extPend ? PFX_EXTBRK : PFX_BRK;
      end else begin
        ctl.emit = 1'b1;
        pfxNext  = PFX_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pfxState <= PFX_NONE;
    else       pfxState <= pfxNext;
  end
endmodule

// File: rtl/kbd_scan_dp.sv
module kbd_scan_dp
  import kbd_scan_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] byteData,
  input  ctlStrobe_t        ctl,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyExt,
  output logic              keyRelease,
  output logic              keyStrobe
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCode    <= '0;
      keyExt     <= 1'b0;
      keyRelease <= 1'b0;
      keyStrobe  <= 1'b0;
    end else begin
      keyStrobe <= ctl.emit;
      if (ctl.emit) begin
        keyCode    <= byteData;
        keyExt     <= ctl.extFlag;
        keyRelease <= ctl.relFlag;
      end
    end
  end
endmodule

// File: rtl/kbd_scan_decoder.sv
module kbd_scan_decoder
  import kbd_scan_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] EXT_BYTE = 8'hE0,
  parameter logic [CODE_W-1:0] BRK_BYTE = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [CODE_W-1:0] byteData,
  input  logic              clearIn,
  input  logic              rxError,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyExt,
  output logic              keyRelease,
  output logic              keyStrobe
);
  ctlStrobe_t ctl;

  kbd_scan_ctrl #(.CODE_W(CODE_W), .EXT_BYTE(EXT_BYTE), .BRK_BYTE(BRK_BYTE)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .clearIn(clearIn), .rxError(rxError), .ctl(ctl)
  );

  kbd_scan_dp #(.CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .byteData(byteData), .ctl(ctl),
    .keyCode(keyCode), .keyExt(keyExt), .keyRelease(keyRelease), .keyStrobe(keyStrobe)
  );
endmodule

// File: rtl/kbd_scan_decoder_chk.sv
module kbd_scan_decoder_chk #(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] EXT_BYTE = 8'hE0,
  parameter logic [CODE_W-1:0] BRK_BYTE = 8'hF0
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic [CODE_W-1:0] byteData,
  input logic              clearIn,
  input logic              rxError,
  input logic [CODE_W-1:0] keyCode,
  input logic              keyExt,
  input logic              keyRelease,
  input logic              keyStrobe
);
  logic isPfx;
  assign isPfx = (byteData == EXT_BYTE) || (byteData == BRK_BYTE);

  // R1: a code byte with nothing pending gives a plain press next cycle
  p_plain_press_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clearIn || rxError) && byteValid && !isPfx && !clearIn && !rxError)
      |=> (keyStrobe && keyCode == $past(byteData) && !keyExt && !keyRelease));

  // R6: prefix bytes never produce an event
  p_prefix_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && isPfx) |=> !keyStrobe);

  // R8: clear or error suppresses any event from the same cycle
  p_drop_no_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn || rxError) |=> !keyStrobe);

  // R9: outputs hold when no byte was accepted
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid) |=> ($stable(keyCode) && $stable(keyExt) && $stable(keyRelease) && !keyStrobe));

  // R1: an event always traces back to an accepted byte
  p_strobe_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe |-> $past(byteValid && !clearIn && !rxError));
endmodule

bind kbd_scan_decoder kbd_scan_decoder_chk #(
  .CODE_W(CODE_W), .EXT_BYTE(EXT_BYTE), .BRK_BYTE(BRK_BYTE)
) chk_i (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
  .clearIn(clearIn), .rxError(rxError), .keyCode(keyCode), .keyExt(keyExt),
  .keyRelease(keyRelease), .keyStrobe(keyStrobe)
);

// File: tb/kbd_scan_decoder_tb.sv
module kbd_scan_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       clearIn = 1'b0;
  logic       rxError = 1'b0;
  logic [7:0] keyCode;
  logic       keyExt, keyRelease, keyStrobe;

  kbd_scan_decoder dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .clearIn(clearIn), .rxError(rxError), .keyCode(keyCode), .keyExt(keyExt),
    .keyRelease(keyRelease), .keyStrobe(keyStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  bit    done   = 0;
  string curReq = "R10";

  // Behavioural reference model
  bit       mExt = 0, mBrk = 0;
  bit       expStrobe = 0, expExt = 0, expRel = 0;
  bit [7:0] expCode = 0;

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rstN) begin
      mExt = 0; mBrk = 0;
      expStrobe = 0; expExt = 0; expRel = 0; expCode = 0;
    end else begin
      expStrobe = 0;
      if (clearIn || rxError) begin
        mExt = 0; mBrk = 0;
      end else if (byteValid) begin
        if (byteData == 8'hE0) mExt = 1;
        else if (byteData == 8'hF0) mBrk = 1;
        else begin
          expStrobe = 1; expCode = byteData; expExt = mExt; expRel = mBrk;
          mExt = 0; mBrk = 0;
        end
      end
    end
  end

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: strobe/ext/rel/code act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done && cycles > 1)
      check(curReq, {keyStrobe, keyExt, keyRelease, keyCode},
                    {expStrobe, expExt, expRel, expCode});
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 0; clearIn = 0; rxError = 0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1; byteData = b; clearIn = 0; rxError = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: act=expired exp=finished");
    finishRun();
  end

  initial begin
    curReq = "R10";
    idle(4);
    @(negedge clk);
    rstN = 1;
    curReq = "R1";
    sendByte(8'h1C); idle(2);
    sendByte(8'h00); idle(1);
    sendByte(8'hFF); idle(2);
    curReq = "R2";
    sendByte(8'hF0); sendByte(8'h1C); idle(2);
    curReq = "R3";
    sendByte(8'hE0); sendByte(8'h75); idle(2);
    curReq = "R4";
    sendByte(8'hE0); sendByte(8'hF0); sendByte(8'h75); idle(2);
    sendByte(8'hF0); sendByte(8'hE0); sendByte(8'h6B); idle(2);
    curReq = "R5";
    sendByte(8'h1C); sendByte(8'h1C); sendByte(8'h1C); idle(3);
    curReq = "R6";
    sendByte(8'hE0); idle(5); sendByte(8'hE0); idle(3); sendByte(8'hF0); idle(4);
    sendByte(8'h11); idle(2);
    curReq = "R7";
    sendByte(8'hF0); sendByte(8'h2A); sendByte(8'h2A); idle(2);
    curReq = "R8";
    sendByte(8'hE0); sendByte(8'hF0);
    @(negedge clk); byteValid = 0; clearIn = 1;
    sendByte(8'h33); idle(2);
    sendByte(8'hF0);
    @(negedge clk); byteValid = 0; rxError = 1;
    sendByte(8'h34); idle(2);
    @(negedge clk); byteValid = 1; byteData = 8'h44; clearIn = 1;
    idle(2);
    sendByte(8'hE0);
    @(negedge clk); byteValid = 1; byteData = 8'h45; rxError = 1;
    sendByte(8'h46); idle(2);
    curReq = "R9";
    sendByte(8'hE0); sendByte(8'h70); idle(6);
    curReq = "R10";
    @(negedge clk); rstN = 0; byteValid = 0;
    idle(3);
    @(negedge clk); rstN = 1;
    idle(2);
    finishRun();
  end
endmodule